// File: doc/BRIEF.md
# Windowed Service Watchdog

This block is a watchdog timer with two programmable windows and a 32-bit register port. Software loads a closed-window length and an open-window length, both counted in clock cycles, and then starts the timer. Each service period starts with the closed window. A restart request (kick) that arrives while the closed window runs is a fault. A kick that arrives while the open window runs is accepted, and the timer starts a new closed window. If the open window runs out with no kick, the block reports a timeout fault.

Every write to the control/status register needs a write key set just before it. The key is spent by that one write. The window lengths can be changed only while the timer is stopped. A fault raises a status flag, which software can clear. It also raises a reset request, which only a block reset clears.

Register map (byte offsets): 0x00 key register (bit 0 = key). 0x04 control/status register: bit 0 run, bit 8 kick (write-only, reads 0), bit 16 fault flag (write 1 to clear). 0x08 reserved (reads 0, writes ignored). 0x0C closed-window length. 0x10 open-window length.

Top module: `win_watchdog`

## Requirements
- R1: After reset, all registers read 0 and `irq_flag` and `rst_req` are low.
- R2: Writing 0x00 with bit 0 set arms the key, and a read of 0x00 then shows bit 0 = 1. A write to 0x04 while the key is not armed is ignored. An accepted write to 0x04 clears the key.
- R3: The lengths at 0x0C and 0x10 are written only while run (bit 0 of 0x04) is 0. Writes to them while run is 1 are ignored, and the registers read back the old value.
- R4: Let E be the clock edge that accepts the write setting run. The closed window is loaded at edge L = E+1. A kick at edges L+1 through L+Lc+1 falls in the closed window (Lc = closed length).
- R5: If no kick arrives, the open-window timeout sets the fault at edge L+Lc+Lo+2 and not before (Lo = open length).
- R6: A kick at any edge from L+Lc+2 through L+Lc+Lo+2 is accepted and causes no fault. That includes the last edge, where the kick wins over the timeout. An accepted kick at edge K starts a new period with K as its load edge.
- R7: A kick in the closed window sets the fault flag (bit 16 of 0x04, and `irq_flag`) and `rst_req` at the same edge.
- R8: Writing 0x04 with bit 16 set under the key clears the fault flag. `rst_req` stays high until reset.
- R9: Bit 8 of 0x04 always reads 0. A kick while run is 0 has no effect.
- R10: Clearing run stops the timer, and no timeout fault follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from `bus_addr` |
| irq_flag | output | 1 | Fault status flag (mirrors bit 16) |
| rst_req | output | 1 | Sticky reset request |

## Verification
The assertions assume the following about the inputs:
- Each write is a single-cycle strobe, with its address and data stable around the sampling edge.
- The window-length width does not exceed the data width.
- Reset is applied before the first access.

The bench changes its inputs only on falling edges, and its write task holds each access for exactly one rising edge. This lets it place a kick on a chosen edge relative to the enable edge, so the boundary edges of both windows can be hit exactly.

// File: rtl/wwin_pkg.sv
// Shared constants and types for the windowed watchdog.
// Assumes byte offsets fit in 5 address bits.
package wwin_pkg;
    localparam int OFS_KEY  = 'h00;
    localparam int OFS_CS   = 'h04;
    localparam int OFS_AUX  = 'h08;
    localparam int OFS_SHUT = 'h0C;
    localparam int OFS_OPEN = 'h10;

    localparam int CS_RUN  = 0;
    localparam int CS_KICK = 8;
    localparam int CS_FLAG = 16;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SHUT = 2'd1,
        PH_OPEN = 2'd2,
        PH_TRIP = 2'd3
    } phase_e;
endpackage

// File: rtl/wwin_regs.sv
// Register file: write key, run bit, window lengths and readback.
// Assumes CNT_W <= DATA_W and DATA_W > CS_FLAG; one access per strobe cycle.
module wwin_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              flag_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run_o,
    output logic              key_o,
    output logic              kick_o,
    output logic              clr_o,
    output logic [CNT_W-1:0]  shut_len_o,
    output logic [CNT_W-1:0]  open_len_o
);
    import wwin_pkg::*;

    logic wr, cs_ok;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr     = bus_sel && bus_we;
    assign cs_ok  = wr && (bus_addr == ADDR_W'(OFS_CS)) && key_o;
    assign kick_o = cs_ok && bus_wdata[CS_KICK];
    assign clr_o  = cs_ok && bus_wdata[CS_FLAG];

    // Key arms on a write to the key register and is spent by one status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            key_o <= 1'b0;
        else if (wr && bus_addr == ADDR_W'(OFS_KEY))
            key_o <= bus_wdata[0];
        else if (cs_ok)
            key_o <= 1'b0;
    end

    // Run bit follows accepted status writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_o <= 1'b0;
        else if (cs_ok)
            run_o <= bus_wdata[CS_RUN];
    end

    // Window lengths load only while the timer is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shut_len_o <= '0;
            open_len_o <= '0;
        end else if (wr && !run_o) begin
            if (bus_addr == ADDR_W'(OFS_SHUT))
                shut_len_o <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFS_OPEN))
                open_len_o <= bus_wdata[CNT_W-1:0];
        end
    end

    // Readback mux; the kick bit and the reserved register read as zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_KEY):  bus_rdata[0] = key_o;
            ADDR_W'(OFS_CS): begin
                bus_rdata[CS_RUN]  = run_o;
                bus_rdata[CS_FLAG] = flag_i;
            end
            ADDR_W'(OFS_SHUT): bus_rdata = DATA_W'(shut_len_o);
            ADDR_W'(OFS_OPEN): bus_rdata = DATA_W'(open_len_o);
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wwin_counter.sv
// Two-phase down-counter: closed window, then open window, then trip.
// Assumes kick_i is a single-cycle pulse from an accepted status write.
module wwin_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] shut_len_i,
    input  logic [CNT_W-1:0] open_len_i,
    output wwin_pkg::phase_e phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             kick_bad_o,
    output logic             expire_o
);
    import wwin_pkg::*;

    logic kick_good, at_zero;

    assign at_zero    = (cnt_o == '0);
    assign kick_bad_o = run_i && kick_i && phase_o == PH_SHUT;
    assign kick_good  = run_i && kick_i && phase_o == PH_OPEN;
    assign expire_o   = run_i && phase_o == PH_OPEN && at_zero && !kick_i;

    // Phase sequencing and down-count; a kick in the open window wins over expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_o <= PH_IDLE;
            cnt_o   <= '0;
        end else begin
            case (phase_o)
                PH_IDLE: begin
                    phase_o <= PH_SHUT;
                    cnt_o   <= shut_len_i;
                end
                PH_SHUT: begin
                    if (kick_bad_o) begin
                        phase_o <= PH_TRIP;
                    end else if (at_zero) begin
                        phase_o <= PH_OPEN;
                        cnt_o   <= open_len_i;
                    end else begin
                        cnt_o <= cnt_o - 1'b1;
                    end
                end
                PH_OPEN: begin
                    if (kick_good) begin
                        phase_o <= PH_SHUT;
                        cnt_o   <= shut_len_i;
                    end else if (at_zero) begin
                        phase_o <= PH_TRIP;
                    end else begin
                        cnt_o <= cnt_o - 1'b1;
                    end
                end
                default: phase_o <= PH_TRIP;
            endcase
        end
    end
endmodule

// File: rtl/wwin_fault.sv
// Fault latch: clearable status flag plus a reset request held until reset.
// Assumes a fault and a clear in the same cycle resolve to the fault.
module wwin_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_bad_i,
    input  logic expire_i,
    input  logic clr_i,
    output logic flag_o,
    output logic rst_req_o
);
    logic hit;
    assign hit = kick_bad_i || expire_i;

    // Status flag: set by a fault, cleared by write-one under the key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (hit)
            flag_o <= 1'b1;
        else if (clr_i)
            flag_o <= 1'b0;
    end

    // Reset request: sticky until block reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req_o <= 1'b0;
        else if (hit)
            rst_req_o <= 1'b1;
    end
endmodule

// File: rtl/win_watchdog.sv
// Windowed watchdog top: wires register file, counter and fault latch.
// Assumes a single synchronous clock and a simple one-cycle access port.
module win_watchdog #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_flag,
    output logic              rst_req
);
    import wwin_pkg::*;

    logic             run_w, key_w, kick_w, clr_w, kick_bad_w, expire_w;
    logic [CNT_W-1:0] shut_len_w, open_len_w, cnt_w;
    phase_e           phase_w;

    wwin_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .flag_i(irq_flag),
        .bus_rdata(bus_rdata), .run_o(run_w), .key_o(key_w), .kick_o(kick_w),
        .clr_o(clr_w), .shut_len_o(shut_len_w), .open_len_o(open_len_w)
    );

    wwin_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run_w), .kick_i(kick_w),
        .shut_len_i(shut_len_w), .open_len_i(open_len_w),
        .phase_o(phase_w), .cnt_o(cnt_w),
        .kick_bad_o(kick_bad_w), .expire_o(expire_w)
    );

    wwin_fault u_fault (
        .clk(clk), .rst_n(rst_n), .kick_bad_i(kick_bad_w), .expire_i(expire_w),
        .clr_i(clr_w), .flag_o(irq_flag), .rst_req_o(rst_req)
    );
endmodule

// File: rtl/win_watchdog_chk.sv
// Property checker for the windowed watchdog, bound into the top module.
// Assumes the bus strobes one access per cycle.
module win_watchdog_chk #(
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              run,
    input logic              key,
    input logic              kick,
    input wwin_pkg::phase_e  phase,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  shut_len,
    input logic [CNT_W-1:0]  open_len,
    input logic              irq_flag,
    input logic              rst_req
);
    import wwin_pkg::*;

    a_r2_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == ADDR_W'(OFS_CS) && !key) |=> $stable(run));

    a_r3_lengths_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> ($stable(shut_len) && $stable(open_len)));

    a_r5_timeout_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase == PH_OPEN && cnt == '0 && !kick) |=> (irq_flag && rst_req));

    a_r6_open_kick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kick && phase == PH_OPEN) |=> (phase == PH_SHUT && cnt == $past(shut_len)));

    a_r7_closed_kick_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (run && kick && phase == PH_SHUT) |=> (irq_flag && rst_req));

    a_r8_rst_req_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind win_watchdog win_watchdog_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .run(run_w), .key(key_w), .kick(kick_w),
    .phase(phase_w), .cnt(cnt_w), .shut_len(shut_len_w), .open_len(open_len_w),
    .irq_flag(irq_flag), .rst_req(rst_req)
);

// File: tb/win_watchdog_tb.sv
module win_watchdog_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LC = 10;
    localparam int LO = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_flag, rst_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_flag(irq_flag), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // One write, accepted at the next rising edge; returns at the following falling edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Program both windows and enable; returns just after the enable edge E.
    task automatic start(input int lc, input int lo);
        wr(5'h00, 32'h1); wr(5'h04, 32'h0);
        wr(5'h0C, lc);   wr(5'h10, lo);
        wr(5'h00, 32'h1); wr(5'h04, 32'h1);
    endtask

    task automatic kick();
        wr(5'h00, 32'h1); wr(5'h04, 32'h101);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(5'h00, d); check("R1 key reg", d, 0);
        rd(5'h04, d); check("R1 status reg", d, 0);
        rd(5'h0C, d); check("R1 closed len", d, 0);
        check("R1 irq_flag", irq_flag, 0);
        check("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        do_reset();
        wr(5'h04, 32'h1);
        rd(5'h04, d); check("R2 locked write ignored", d, 0);
        wr(5'h00, 32'h1);
        rd(5'h00, d); check("R2 key armed", d, 1);
        wr(5'h0C, 32'd7);
        wr(5'h04, 32'h1);
        rd(5'h00, d); check("R2 key spent", d, 0);
        rd(5'h04, d); check("R2 run set", d, 1);
        wr(5'h0C, 32'd99);
        rd(5'h0C, d); check("R3 length frozen while running", d, 7);
    endtask

    task automatic t_timeout();
        do_reset();
        start(LC, LO);
        idle(LC + LO + 2);
        check("R5 no fault one edge early", irq_flag, 0);
        idle(1);
        check("R5 timeout fault", irq_flag, 1);
        check("R5 timeout reset request", rst_req, 1);
    endtask

    task automatic t_early();
        logic [31:0] d;
        do_reset();
        start(LC, LO);
        idle(LC);          // kick lands at edge E+LC+2 = L+LC+1, last closed edge
        kick();
        check("R4 R7 closed kick flag", irq_flag, 1);
        check("R7 closed kick reset request", rst_req, 1);
        rd(5'h04, d); check("R7 status bit16", d, 32'h10001);
        wr(5'h00, 32'h1); wr(5'h04, 32'h10001);
        check("R8 flag cleared", irq_flag, 0);
        check("R8 rst_req held", rst_req, 1);
        do_reset();
        check("R8 rst_req cleared by reset", rst_req, 0);
    endtask

    task automatic t_open();
        logic [31:0] d;
        do_reset();
        start(LC, LO);
        idle(LC + 1);      // kick at E+LC+3 = L+LC+2, first open edge
        kick();
        check("R6 first open edge kick accepted", irq_flag, 0);
        rd(5'h04, d); check("R9 kick bit reads zero", d, 1);
        idle(LC + LO);     // next kick at K+LC+LO+2, last open edge
        kick();
        check("R6 last open edge kick accepted", irq_flag, 0);
        idle(LC + LO + 1);
        check("R6 no fault before new timeout", irq_flag, 0);
        idle(1);
        check("R6 timeout after reload", irq_flag, 1);
    endtask

    task automatic t_stop();
        do_reset();
        start(LC, LO);
        idle(3);
        wr(5'h00, 32'h1); wr(5'h04, 32'h0);
        idle(LC + LO + 8);
        check("R10 stopped timer no fault", irq_flag, 0);
        wr(5'h00, 32'h1); wr(5'h04, 32'h100);
        idle(2);
        check("R9 kick while stopped ignored", irq_flag, 0);
        check("R9 kick while stopped no reset request", rst_req, 0);
    endtask

    initial begin
        t_reset();
        t_lock();
        t_timeout();
        t_early();
        t_open();
        t_stop();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule